// File: doc/BRIEF.md
# Peripheral Reset and Clock Handshake Sequencer

This block runs a complete reset cycle for a neighbouring peripheral. It does this through four write-one control strobes and two status readbacks. A single-cycle start request launches the sequence. The sequencer then issues four strobes, one at a time and always in this order:

1. raise the reset;
2. stop the clock;
3. drop the reset;
4. restart the clock.

After each strobe the block polls the matching status line once per cycle. It moves on only when that line shows the level that the strobe should produce.

Every wait has a bound. If the status line does not reach its expected level within a parameterised number of polls, the sequence stops. The error flag then rises and a two-bit code names the step that stalled. The flag and the code stay until the next start. When the whole sequence finishes cleanly, a one-cycle done pulse marks the end. A start that arrives while a sequence is in progress has no effect.

Top module: `rcs_sequencer`

## Requirements
- R1: After reset, all four strobes, `done_o` and `error_o` are low, and `err_step_o` is 0.
- R2: A start seen while idle produces a one-cycle `rst_on_o` strobe in the following cycle.
- R3: The strobes come in the order `rst_on_o`, `clk_off_o`, `rst_off_o`, `clk_on_o`, at most one per cycle. Each later strobe appears in the cycle after the previous step's status match is sampled.
- R4: The expected status levels are fixed per step. Step 0 waits for `rst_st_i`=1. Step 1 waits for `clk_st_i`=0. Step 2 waits for `rst_st_i`=0. Step 3 waits for `clk_st_i`=1. Polling begins in the cycle that shows the step's strobe.
- R5: Each step allows at most TIMEOUT_POLLS polls, one per cycle. A match on the last allowed poll still advances the sequence. If no poll matches, `error_o` rises in the cycle after the last poll.
- R6: Once `error_o` is high, it stays high and `err_step_o` holds the failing step index until the next accepted start. No further strobes are issued. The step index is 0 for reset-on, 1 for clock-off, 2 for reset-off and 3 for clock-on.
- R7: `done_o` is high for exactly one cycle, namely the cycle after the step-3 match is sampled, and never together with `error_o`.
- R8: A start asserted while a sequence is running is ignored. It neither restarts the sequence nor changes its timing.
- R9: An accepted start clears `error_o` in the cycle its first strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled each cycle |
| rst_st_i | input | 1 | Reset status readback (1 = peripheral held in reset) |
| clk_st_i | input | 1 | Clock status readback (1 = clock running) |
| rst_on_o | output | 1 | Strobe: assert peripheral reset |
| clk_off_o | output | 1 | Strobe: stop peripheral clock |
| rst_off_o | output | 1 | Strobe: release peripheral reset |
| clk_on_o | output | 1 | Strobe: restart peripheral clock |
| done_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | Sticky timeout flag |
| err_step_o | output | 2 | Index of the step that timed out |

## Verification
The checker assumes the following about the inputs:
- Both status lines are synchronous to `clk_i` and are stable across each sampling edge.
- `start_i` may be asserted in any cycle, including during a running sequence. The ordering and quiet-after-error properties do not depend on its timing.

The bench meets these assumptions with a behavioural peripheral model that is clocked on the same edge. The model moves a status line only after a programmed delay following the matching strobe. It restores the rest levels (reset low, clock running) before each run. Start pulses are driven between edges. One of them is deliberately placed inside every second sequence.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int NUM_STEPS = 4;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    // Step indices; the order is the sequence order
    localparam logic [STEP_W-1:0] STEP_RST_ON  = 2'd0;
    localparam logic [STEP_W-1:0] STEP_CLK_OFF = 2'd1;
    localparam logic [STEP_W-1:0] STEP_RST_OFF = 2'd2;
    localparam logic [STEP_W-1:0] STEP_CLK_ON  = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rcs_state_e;

    typedef struct packed {
        rcs_state_e               state;
        logic [STEP_W-1:0]        step;
        logic [NUM_STEPS-1:0]     pulse;
        logic                     done;
        logic                     err;
        logic [STEP_W-1:0]        err_step;
    } rcs_seq_t;

endpackage

// File: rtl/rcs_step_match.sv
module rcs_step_match
    import rcs_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic              rst_st_i,
    input  logic              clk_st_i,
    output logic              hit_o
);

    logic [NUM_STEPS-1:0] hit_vec;

    // Odd steps watch the clock, even steps the reset; first and last want 1
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        localparam logic WANT   = (k == 0) || (k == NUM_STEPS - 1);
        localparam bit   ON_CLK = (k % 2) == 1;
        if (ON_CLK) begin : g_clk
            assign hit_vec[k] = (clk_st_i == WANT);
        end else begin : g_rst
            assign hit_vec[k] = (rst_st_i == WANT);
        end
    end

    assign hit_o = hit_vec[step_i];

endmodule

// File: rtl/rcs_poll_timer.sv
module rcs_poll_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic en_i,
    output logic last_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/rcs_sequencer.sv
module rcs_sequencer
    import rcs_pkg::*;
#(
    parameter int TIMEOUT_POLLS = 1000000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       rst_st_i,
    input  logic       clk_st_i,
    output logic       rst_on_o,
    output logic       clk_off_o,
    output logic       rst_off_o,
    output logic       clk_on_o,
    output logic       done_o,
    output logic       error_o,
    output logic [1:0] err_step_o
);

    rcs_seq_t seq_d, seq_q;
    logic     hit;
    logic     tmr_clear;
    logic     tmr_en;
    logic     tmr_last;
    logic     seq_running;

    rcs_step_match i_match (
        .step_i   (seq_q.step),
        .rst_st_i (rst_st_i),
        .clk_st_i (clk_st_i),
        .hit_o    (hit)
    );

    rcs_poll_timer #(
        .LIMIT (TIMEOUT_POLLS)
    ) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (tmr_clear),
        .en_i    (tmr_en),
        .last_o  (tmr_last)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.pulse = '0;
        seq_d.done  = 1'b0;
        tmr_clear   = 1'b0;
        tmr_en      = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state    = ST_WAIT;
                    seq_d.step     = STEP_RST_ON;
                    seq_d.pulse    = NUM_STEPS'(1);
                    seq_d.err      = 1'b0;
                    seq_d.err_step = '0;
                    tmr_clear      = 1'b1;
                end
            end
            ST_WAIT: begin
                if (hit) begin
                    tmr_clear = 1'b1;
                    if (seq_q.step == STEP_CLK_ON) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.step  = seq_q.step + STEP_W'(1);
                        seq_d.pulse = NUM_STEPS'(1) << (seq_q.step + STEP_W'(1));
                    end
                end else if (tmr_last) begin
                    seq_d.state    = ST_IDLE;
                    seq_d.err      = 1'b1;
                    seq_d.err_step = seq_q.step;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_IDLE, step: '0, pulse: '0, done: 1'b0,
                       err: 1'b0, err_step: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_running = (seq_q.state == ST_WAIT);

    assign rst_on_o   = seq_q.pulse[STEP_RST_ON];
    assign clk_off_o  = seq_q.pulse[STEP_CLK_OFF];
    assign rst_off_o  = seq_q.pulse[STEP_RST_OFF];
    assign clk_on_o   = seq_q.pulse[STEP_CLK_ON];
    assign done_o     = seq_q.done;
    assign error_o    = seq_q.err;
    assign err_step_o = seq_q.err_step;

endmodule

// File: rtl/rcs_sequencer_chk.sv
module rcs_sequencer_chk #(
    parameter int TIMEOUT_POLLS = 1000000
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic       running_i,
    input logic       rst_on_o,
    input logic       clk_off_o,
    input logic       rst_off_o,
    input logic       clk_on_o,
    input logic       done_o,
    input logic       error_o,
    input logic [1:0] err_step_o
);

    logic [3:0]  pulses;
    logic [3:0]  last_q;
    logic [31:0] quiet_q;

    assign pulses = {clk_on_o, rst_off_o, clk_off_o, rst_on_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            last_q  <= '0;
            quiet_q <= '0;
        end else begin
            if (|pulses) begin
                last_q <= pulses;
            end
            if ((|pulses) || !running_i) begin
                quiet_q <= '0;
            end else begin
                quiet_q <= quiet_q + 32'd1;
            end
        end
    end

    assert_pulse_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pulses));

    assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pulses) |=> ((pulses & $past(pulses)) == 4'b0));

    assert_first_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_on_o |-> ($past(start_i) && !$past(running_i)));

    assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|pulses) && !rst_on_o) |-> (pulses == (last_q << 1)));

    assert_poll_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_i |-> (quiet_q < 32'(TIMEOUT_POLLS)));

    assert_error_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (error_o && !start_i) |=> (error_o && $stable(err_step_o)));

    assert_error_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> (pulses == 4'b0));

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_no_error_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !error_o);

    assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && start_i) |=> !rst_on_o);

    assert_error_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !running_i) |=> !error_o);

endmodule

bind rcs_sequencer rcs_sequencer_chk #(
    .TIMEOUT_POLLS (TIMEOUT_POLLS)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .running_i  (seq_running),
    .rst_on_o   (rst_on_o),
    .clk_off_o  (clk_off_o),
    .rst_off_o  (rst_off_o),
    .clk_on_o   (clk_on_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .err_step_o (err_step_o)
);

// File: tb/test_rcs_sequencer.sv
module test_rcs_sequencer;

    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rst_st;
    logic       clk_st;
    logic       rst_on, clk_off, rst_off, clk_on;
    logic       done, error;
    logic [1:0] err_step;

    int checks = 0;
    int errors = 0;
    int dly [4];
    logic mdl_init = 1'b0;
    logic mdl_arm;
    int   mdl_cd;
    int   mdl_step;

    always #4 clk = ~clk;

    rcs_sequencer #(.TIMEOUT_POLLS(T)) i_rcs_sequencer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .rst_st_i   (rst_st),
        .clk_st_i   (clk_st),
        .rst_on_o   (rst_on),
        .clk_off_o  (clk_off),
        .rst_off_o  (rst_off),
        .clk_on_o   (clk_on),
        .done_o     (done),
        .error_o    (error),
        .err_step_o (err_step)
    );

    task automatic apply_level(input int k);
        case (k)
            0: rst_st <= 1'b1;
            1: clk_st <= 1'b0;
            2: rst_st <= 1'b0;
            default: clk_st <= 1'b1;
        endcase
    endtask

    // Peripheral model: status moves dly[k] edges after the strobe is seen
    always @(posedge clk) begin
        if (mdl_init) begin
            rst_st  <= 1'b0;
            clk_st  <= 1'b1;
            mdl_arm <= 1'b0;
            mdl_cd  <= 0;
        end else if (rst_on || clk_off || rst_off || clk_on) begin
            mdl_step = rst_on ? 0 : clk_off ? 1 : rst_off ? 2 : 3;
            if (dly[mdl_step] == 0) begin
                apply_level(mdl_step);
                mdl_arm <= 1'b0;
            end else begin
                mdl_arm  <= 1'b1;
                mdl_cd   <= dly[mdl_step] - 1;
            end
        end else if (mdl_arm) begin
            if (mdl_cd == 0) begin
                apply_level(mdl_step);
                mdl_arm <= 1'b0;
            end else begin
                mdl_cd <= mdl_cd - 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_seq(input int combo);
        int c [4];
        int e;
        int finish_cyc;
        int done_cyc;
        int err_cyc;
        int exp_pulse;
        // program delays from the base-4 digits of combo
        for (int k = 0; k < 4; k++) dly[k] = (combo >> (2 * k)) & 3;
        e = 4;
        for (int k = 3; k >= 0; k--) if (dly[k] >= T - 1) e = k;
        c[0] = 1;
        for (int k = 1; k < 4; k++) c[k] = c[k-1] + dly[k-1] + 2;
        done_cyc = (e == 4) ? c[3] + dly[3] + 2 : -1;
        err_cyc  = (e == 4) ? -1 : c[e] + T;
        finish_cyc = (e == 4) ? done_cyc + 2 : err_cyc + 3;
        @(negedge clk);
        mdl_init = 1'b1;
        @(negedge clk);
        mdl_init = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        for (int cyc = 1; cyc <= finish_cyc; cyc++) begin
            exp_pulse = 0;
            for (int k = 0; k < 4; k++)
                if (k <= e && cyc == c[k]) exp_pulse |= (1 << k);
            chk((cyc == 1) ? "R2 first strobe" : "R3 strobe order/R4 levels",
                {clk_on, rst_off, clk_off, rst_on}, exp_pulse);
            chk("R7 done pulse", done, (cyc == done_cyc) ? 1 : 0);
            chk((cyc == 1) ? "R9 error cleared" : "R5 timeout/R6 error hold",
                error, (err_cyc > 0 && cyc >= err_cyc) ? 1 : 0);
            if (err_cyc > 0 && cyc >= err_cyc) chk("R6 error step", err_step, e);
            // R8: a start inside the running sequence must change nothing
            if (combo % 2 == 1 && cyc == 2) start = 1'b1;
            else start = 1'b0;
            @(posedge clk);
            #1;
        end
        start = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) dly[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobes", {clk_on, rst_off, clk_off, rst_on}, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset error", error, 0);
        chk("R1 reset step", err_step, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 idle after reset", {done, error, clk_on, rst_off, clk_off, rst_on}, 0);
        for (int combo = 0; combo < 256; combo++) run_seq(combo);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule